// File: doc/BRIEF.md
# Pin Port with Atomic Set, Clear, Drive and Release Strobes

This block is a memory-mapped general-purpose pin port of up to 32 pins. Software never reads, modifies and writes back a shadow value. Each write goes to one of four strobe offsets, and at that offset every data bit written as 1 acts on its pin while every bit written as 0 leaves its pin alone. Two strobes move the output latch high or low. The other two turn the pin's output driver on or put it into high impedance. A fifth offset is read-only and returns the pin levels after they pass through a synchronizer.

The bus side is a plain register slave with an address, a single-cycle write enable, a write data word and a combinational read data word. The pad side carries three vectors per pin: the output value, the output enable and the input level. A write takes effect at the clock edge on which the write enable is sampled.

Top module: `gpio_strobe_port`

## Requirements
- R1: After reset, pad_out and pad_oe are all 0.
- R2: A write to offset 0x00 sets pad_out[n] to 1 for each bit n written as 1. Every other pad_out bit and all of pad_oe keep their values. The change is visible after the clock edge that samples the write.
- R3: A write to offset 0x10 sets pad_out[n] to 0 for each bit n written as 1. Every other pad_out bit and all of pad_oe keep their values.
- R4: A write to offset 0x20 sets pad_oe[n] to 1 for each bit n written as 1. Every other pad_oe bit and all of pad_out keep their values.
- R5: A write to offset 0x30 sets pad_oe[n] to 0 for each bit n written as 1. Every other pad_oe bit and all of pad_out keep their values.
- R6: While bus_addr is 0x40, bus_rdata bit n reflects pad_in[n] through two flops. A pad level change becomes visible after the second rising edge and is not visible after the first. Data bit n maps to pin n, with bit 0 in the least significant byte.
- R7: bus_rdata is 0 whenever bus_addr is anything other than 0x40. This includes the four strobe offsets.
- R8: A write to any offset other than 0x00, 0x10, 0x20 or 0x30 leaves pad_out and pad_oe unchanged. This includes offset 0x40 and any other unmapped address. Cycles with bus_wr low also leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data, bit n acts on pin n |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| pad_out | output | NUM_PINS (32) | Output latch value per pin |
| pad_oe | output | NUM_PINS (32) | Output driver enable per pin |
| pad_in | input | NUM_PINS (32) | Asynchronous pad level per pin |

## Verification
The set and clear strobes are exercised with overlapping, sparse and all-ones masks on top of a non-trivial latch state. A mismatch then shows whether bits written as 0 were disturbed, or whether the wrong polarity or the wrong register was hit. The driver strobes are interleaved with value strobes, which separates a decode that crosses the two registers from a correct one. The input path uses an asymmetric pattern sampled one edge and two edges after a change, so the latency and the bit order are both pinned down. Writes to the read offset and to unmapped offsets follow a known state, which exposes any decode that ignores address bits.

// File: rtl/gpio_sp_pkg.sv
package gpio_sp_pkg;

   // Byte offsets; software depends on these exact values.
   localparam logic [7:0] OFS_SET = 8'h00;
   localparam logic [7:0] OFS_CLR = 8'h10;
   localparam logic [7:0] OFS_DRV = 8'h20;
   localparam logic [7:0] OFS_HIZ = 8'h30;
   localparam logic [7:0] OFS_LVL = 8'h40;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_SET,
      ACC_CLR,
      ACC_DRV,
      ACC_HIZ,
      ACC_LVL
   } acc_kind_e;

endpackage

// File: rtl/gpio_sp_decode.sv
module gpio_sp_decode
   import gpio_sp_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);

   always_comb begin
      if      (addr == ADDR_W'(OFS_SET)) kind = ACC_SET;
      else if (addr == ADDR_W'(OFS_CLR)) kind = ACC_CLR;
      else if (addr == ADDR_W'(OFS_DRV)) kind = ACC_DRV;
      else if (addr == ADDR_W'(OFS_HIZ)) kind = ACC_HIZ;
      else if (addr == ADDR_W'(OFS_LVL)) kind = ACC_LVL;
      else                               kind = ACC_NONE;
   end

endmodule

// File: rtl/gpio_sp_strobe_reg.sv
module gpio_sp_strobe_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_stb,
   input  logic             lo_stb,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                   q[g] <= 1'b0;
         else if (hi_stb && mask[g])   q[g] <= 1'b1;
         else if (lo_stb && mask[g])   q[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/gpio_sp_sync.sv
module gpio_sp_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_strobe_port.sv
module gpio_strobe_port
   import gpio_sp_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic [NUM_PINS-1:0] pad_in
);

   localparam int PAD_W = DATA_W - NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must be in 1..DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x40");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   acc_kind_e           kind;
   logic [NUM_PINS-1:0] mask;
   logic [NUM_PINS-1:0] lvl_q;

   gpio_sp_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .kind (kind)
   );

   assign mask = bus_wdata[NUM_PINS-1:0];

   gpio_sp_strobe_reg #(.WIDTH(NUM_PINS)) u_val (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_stb (bus_wr && kind == ACC_SET),
      .lo_stb (bus_wr && kind == ACC_CLR),
      .mask   (mask),
      .q      (pad_out)
   );

   gpio_sp_strobe_reg #(.WIDTH(NUM_PINS)) u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_stb (bus_wr && kind == ACC_DRV),
      .lo_stb (bus_wr && kind == ACC_HIZ),
      .mask   (mask),
      .q      (pad_oe)
   );

   gpio_sp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (lvl_q)
   );

   if (PAD_W > 0) begin : g_rd_pad
      assign bus_rdata = (kind == ACC_LVL) ? {{PAD_W{1'b0}}, lvl_q} : '0;
   end else begin : g_rd_full
      assign bus_rdata = (kind == ACC_LVL) ? lvl_q : '0;
   end

endmodule

// File: rtl/gpio_sp_checker.sv
module gpio_sp_checker #(
   parameter int NUM_PINS    = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_in
);

   logic [NUM_PINS-1:0] m;
   logic                a_set, a_clr, a_drv, a_hiz, a_lvl, mapped;
   logic [1:0]          age_q;

   assign m      = bus_wdata[NUM_PINS-1:0];
   assign a_set  = bus_addr == ADDR_W'(8'h00);
   assign a_clr  = bus_addr == ADDR_W'(8'h10);
   assign a_drv  = bus_addr == ADDR_W'(8'h20);
   assign a_hiz  = bus_addr == ADDR_W'(8'h30);
   assign a_lvl  = bus_addr == ADDR_W'(8'h40);
   assign mapped = a_set | a_clr | a_drv | a_hiz;

   always_ff @(posedge clk) begin
      if (!rst_n)          age_q <= 2'd0;
      else if (age_q != 2) age_q <= age_q + 2'd1;
   end

   // R2
   set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && a_set) |=> (((pad_out ^ ($past(pad_out) | $past(m))) == '0)
                             && $stable(pad_oe)));

   // R3
   clr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && a_clr) |=> (((pad_out ^ ($past(pad_out) & ~$past(m))) == '0)
                             && $stable(pad_oe)));

   // R4
   drv_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && a_drv) |=> (((pad_oe ^ ($past(pad_oe) | $past(m))) == '0)
                             && $stable(pad_out)));

   // R5
   drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && a_hiz) |=> (((pad_oe ^ ($past(pad_oe) & ~$past(m))) == '0)
                             && $stable(pad_out)));

   // R7
   rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !a_lvl |-> (bus_rdata == '0));

   // R8
   no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && mapped) |=> ($stable(pad_out) && $stable(pad_oe)));

   if (SYNC_STAGES == 2) begin : g_lat
      // R6
      lvl_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_lvl && age_q == 2'd2) |-> (bus_rdata[NUM_PINS-1:0] == $past(pad_in, 2)));
   end

endmodule

bind gpio_strobe_port gpio_sp_checker #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
   .pad_oe(pad_oe), .pad_in(pad_in)
);

// File: tb/gpio_strobe_port_tb.sv
`timescale 1ns/1ps
module gpio_strobe_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_out, pad_oe;
   logic [31:0] pad_in = '0;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] exp_out = '0;
   logic [31:0] exp_oe  = '0;

   always #2.5 clk = ~clk;

   gpio_strobe_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_in(pad_in)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic check_pads(string req);
      check({req, " pad_out"}, pad_out, exp_out);
      check({req, " pad_oe"},  pad_oe,  exp_oe);
   endtask

   task automatic t_reset;
      check_pads("R1");
   endtask

   task automatic t_set;
      wr(8'h00, 32'hA5A5_0F0F); exp_out = 32'hA5A5_0F0F; check_pads("R2");
      wr(8'h00, 32'h0000_F0F1); exp_out |= 32'h0000_F0F1; check_pads("R2");
      wr(8'h00, 32'h0000_0000);                           check_pads("R2");
   endtask

   task automatic t_clear;
      wr(8'h10, 32'h0000_FF01); exp_out &= ~32'h0000_FF01; check_pads("R3");
      wr(8'h10, 32'h8000_0000); exp_out &= ~32'h8000_0000; check_pads("R3");
      wr(8'h00, 32'hFFFF_FFFF); exp_out = 32'hFFFF_FFFF;   check_pads("R2");
      wr(8'h10, 32'hFFFF_FFFF); exp_out = 32'h0;           check_pads("R3");
      wr(8'h00, 32'h0F0F_3C3C); exp_out = 32'h0F0F_3C3C;   check_pads("R2");
   endtask

   task automatic t_drive;
      wr(8'h20, 32'hF00F_0001); exp_oe = 32'hF00F_0001; check_pads("R4");
      wr(8'h20, 32'h0000_0110); exp_oe |= 32'h0000_0110; check_pads("R4");
      wr(8'h30, 32'h000F_0010); exp_oe &= ~32'h000F_0010; check_pads("R5");
      wr(8'h30, 32'h0000_0000);                           check_pads("R5");
      wr(8'h00, 32'h1000_0000); exp_out |= 32'h1000_0000; check_pads("R2");
   endtask

   task automatic t_input;
      @(negedge clk);
      bus_addr = 8'h40;
      pad_in   = 32'h8000_0001;
      @(negedge clk);
      check("R6 one edge", bus_rdata, 32'h0);
      @(negedge clk);
      check("R6 two edges", bus_rdata, 32'h8000_0001);
      pad_in = 32'h1234_5678;
      @(negedge clk);
      check("R6 one edge", bus_rdata, 32'h8000_0001);
      @(negedge clk);
      check("R6 two edges", bus_rdata, 32'h1234_5678);
   endtask

   task automatic t_read_zero;
      pad_in = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      foreach (addrs[i]) begin end
      bus_addr = 8'h00; #0.1; check("R7 rd 0x00", bus_rdata, 32'h0);
      bus_addr = 8'h10; #0.1; check("R7 rd 0x10", bus_rdata, 32'h0);
      bus_addr = 8'h20; #0.1; check("R7 rd 0x20", bus_rdata, 32'h0);
      bus_addr = 8'h30; #0.1; check("R7 rd 0x30", bus_rdata, 32'h0);
      bus_addr = 8'h44; #0.1; check("R7 rd 0x44", bus_rdata, 32'h0);
      bus_addr = 8'hC0; #0.1; check("R7 rd 0xC0", bus_rdata, 32'h0);
      bus_addr = 8'h40; #0.1; check("R6 rd 0x40", bus_rdata, 32'hFFFF_FFFF);
   endtask

   logic [7:0] addrs [3] = '{8'h40, 8'h08, 8'h80};

   task automatic t_unmapped;
      wr(8'h40, 32'hFFFF_FFFF); check_pads("R8 wr 0x40");
      wr(8'h08, 32'hFFFF_FFFF); check_pads("R8 wr 0x08");
      wr(8'h80, 32'hFFFF_FFFF); check_pads("R8 wr 0x80");
      wr(8'hB0, 32'hFFFF_FFFF); check_pads("R8 wr 0xB0");
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      bus_wdata = '0;
      check_pads("R8 no wr");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_clear();
      t_drive();
      t_input();
      t_read_zero();
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule